// File: doc/BRIEF.md
# External Bus Hold Arbiter

This block decides who drives a CPU's external memory bus: the core or an outside bus master that asks for the bus through an active-low hold request (`hold_n`). When the bus is safe to give away, the arbiter lowers an active-low acknowledge (`hlda_n`) and turns the bus-drive enable off. A safe moment is the end of any external bus cycle in progress. The core keeps executing while it is on hold. The arbiter stalls it only when it needs an external access. In that case the arbiter lowers an active-low bus request (`breq_n`) towards the holding master. It then blocks every interrupt, including the non-maskable one, until the master lets go, and takes the bus back in the state time that acknowledge rises.

All decisions are taken on state-time boundaries, marked by the single-cycle `state_tick` pulse. An internal cycle timer tracks how long the current external bus cycle lasts. The length depends on the cycle's width and its wait-state count. The worst-case grant latency follows from that length.

States: `ST_OWN` (core drives the bus), `ST_HELD` (bus given away, core running), `ST_REQ` (core waiting for the bus, bus request low, interrupts blocked), `ST_RESUME` (first state time after reclaim, in which the pending access is launched). Transitions, all taken on a tick:
- OWN→HELD when hold is low at a cycle boundary.
- HELD→OWN when hold is high.
- HELD→REQ when the core needs an external access.
- REQ→RESUME when hold is high.
- RESUME→OWN unconditionally.

Top module: `bus_hold_arbiter`

## Requirements
- R1: A synchronous reset leaves `hlda_n` and `breq_n` high and `bus_drive_en` high, so the core owns the bus.
- R2: `hlda_n` falls only at the end of an external bus cycle, never inside one. `bus_drive_en` goes low in the same state time that `hlda_n` goes low.
- R3: With `bus_kind` = 2'b00 (internal or idle; 2'b11 behaves the same), `hlda_n` falls on the first tick that samples `hold_n` low. This is a latency of 1 state time, within the 1.5 bound.
- R4: During a 16-bit external cycle (`bus_kind` = 2'b01, length 2 + W state times), the worst-case grant latency is 2 + W state times. This is within 2.5 + W.
- R5: During an 8-bit external cycle (`bus_kind` = 2'b10, length 2 + 2W state times), the worst-case grant latency is 2 + 2W state times. This is within 2.5 + 2W.
- R6: While on hold, a core request with `bus_kind` = 2'b00 causes no stall and no bus request.
- R7: While on hold, an external core request (`bus_kind` 2'b01 or 2'b10) raises `core_stall` at once. It lowers `breq_n` on the next tick, and `breq_n` stays low until hold is released.
- R8: While `breq_n` is low, neither `irq_accept` nor `nmi_accept` is asserted. At any other time each follows its pending input.
- R9: Exactly one state time after `hold_n` is sampled high, `hlda_n` and `breq_n` rise and `bus_drive_en` rises in the same state time.
- R10: A hold request made in the state time of a reclaim is not granted until the pending core access has finished.
- R11: Outputs change only on clock edges where `state_tick` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| state_tick | input | 1 | One-cycle pulse marking a state-time boundary |
| hold_n | input | 1 | Hold request from external master, active low |
| core_ext_req | input | 1 | Core wants a bus access |
| bus_kind | input | 2 | Access type: 00 internal/idle, 01 16-bit external, 10 8-bit external, 11 as 00 |
| wait_states | input | WS_W | Wait states of the access |
| irq_pend | input | 1 | Maskable interrupt pending |
| nmi_pend | input | 1 | Non-maskable interrupt pending |
| hlda_n | output | 1 | Hold acknowledge, active low |
| breq_n | output | 1 | Bus request to holding master, active low |
| bus_drive_en | output | 1 | Core may drive external bus |
| core_stall | output | 1 | Core must wait for the bus |
| irq_accept | output | 1 | Maskable interrupt may be taken |
| nmi_accept | output | 1 | Non-maskable interrupt may be taken |

## Verification
Some properties are checked by assertions on every cycle:
- drive enable and acknowledge never overlap;
- a grant happens only with no bus cycle open;
- bus request appears only inside hold, and interrupts stay masked while it is low;
- hold release is followed by reclaim one state time later;
- outputs stay still between ticks.

The exact grant latencies for each access width and wait-state count are measured only by the bench's scenarios, as is the deferral of a hold that arrives during reclaim. The same applies to the core running on without a stall during hold and to the reset values.

// File: rtl/bha_pkg.sv
package bha_pkg;

    typedef enum logic [1:0] {
        BK_IDLE  = 2'b00,
        BK_EXT16 = 2'b01,
        BK_EXT8  = 2'b10,
        BK_RSVD  = 2'b11
    } bus_kind_t;

    typedef enum logic [1:0] {
        ST_OWN    = 2'b00,
        ST_HELD   = 2'b01,
        ST_REQ    = 2'b10,
        ST_RESUME = 2'b11
    } own_state_t;

    function automatic logic kind_is_external(input logic [1:0] kind);
        return (kind == BK_EXT16) || (kind == BK_EXT8);
    endfunction

endpackage

// File: rtl/bha_cycle_timer.sv
module bha_cycle_timer
    import bha_pkg::*;
#(
    parameter int WS_W  = 3,
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             start,
    input  logic [1:0]       kind,
    input  logic [WS_W-1:0]  waits,
    output logic [CNT_W-1:0] cyc_left,
    output logic             at_boundary,
    output logic             cyc_idle
);

    logic [CNT_W-1:0] load_len;
    logic [CNT_W-1:0] ws_ext;

    assign ws_ext = CNT_W'(waits);

    // length of the external cycle in state times
    always_comb begin
        unique case (bus_kind_t'(kind))
            BK_EXT16: load_len = CNT_W'(2) + ws_ext;
            BK_EXT8:  load_len = CNT_W'(2) + (ws_ext << 1);
            default:  load_len = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cyc_left <= '0;
        end else if (tick) begin
            if (cyc_left != '0) begin
                cyc_left <= cyc_left - CNT_W'(1);
            end else if (start) begin
                cyc_left <= load_len;
            end
        end
    end

    assign cyc_idle    = (cyc_left == '0);
    assign at_boundary = (cyc_left <= CNT_W'(1));

endmodule

// File: rtl/bha_own_fsm.sv
module bha_own_fsm
    import bha_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       hold_n,
    input  logic       need_bus,
    input  logic       at_boundary,
    input  logic       cyc_idle,
    output own_state_t state,
    output logic       start_cycle,
    output logic       hlda_n,
    output logic       breq_n,
    output logic       drive_en,
    output logic       stall,
    output logic       irq_block
);

    own_state_t next_state;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_OWN;
        end else if (tick) begin
            state <= next_state;
        end
    end

    // transitions
    always_comb begin
        next_state = state;
        unique case (state)
            ST_OWN: begin
                if (!hold_n && at_boundary) next_state = ST_HELD;
            end
            ST_HELD: begin
                if (hold_n)        next_state = ST_OWN;
                else if (need_bus) next_state = ST_REQ;
            end
            ST_REQ: begin
                if (hold_n) next_state = ST_RESUME;
            end
            ST_RESUME: begin
                next_state = ST_OWN;
            end
        endcase
    end

    // outputs
    always_comb begin
        hlda_n      = 1'b1;
        breq_n      = 1'b1;
        drive_en    = 1'b1;
        stall       = 1'b0;
        irq_block   = 1'b0;
        start_cycle = 1'b0;
        unique case (state)
            ST_OWN: begin
                start_cycle = need_bus && cyc_idle && hold_n;
            end
            ST_HELD: begin
                hlda_n   = 1'b0;
                drive_en = 1'b0;
                stall    = need_bus;
            end
            ST_REQ: begin
                hlda_n    = 1'b0;
                breq_n    = 1'b0;
                drive_en  = 1'b0;
                stall     = need_bus;
                irq_block = 1'b1;
            end
            ST_RESUME: begin
                start_cycle = need_bus && cyc_idle;
            end
        endcase
    end

endmodule

// File: rtl/bha_irq_gate.sv
module bha_irq_gate (
    input  logic block,
    input  logic irq_pend,
    input  logic nmi_pend,
    output logic irq_accept,
    output logic nmi_accept
);

    always_comb begin
        irq_accept = irq_pend && !block;
        nmi_accept = nmi_pend && !block;
    end

endmodule

// File: rtl/bus_hold_arbiter.sv
module bus_hold_arbiter
    import bha_pkg::*;
#(
    parameter int WS_W = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            state_tick,
    input  logic            hold_n,
    input  logic            core_ext_req,
    input  logic [1:0]      bus_kind,
    input  logic [WS_W-1:0] wait_states,
    input  logic            irq_pend,
    input  logic            nmi_pend,
    output logic            hlda_n,
    output logic            breq_n,
    output logic            bus_drive_en,
    output logic            core_stall,
    output logic            irq_accept,
    output logic            nmi_accept
);

    localparam int MAX_LEN = 2 + 2 * ((1 << WS_W) - 1);
    localparam int CNT_W   = $clog2(MAX_LEN + 1);

    logic             need_bus;
    logic             start_cycle;
    logic             at_boundary;
    logic             cyc_idle;
    logic             irq_block;
    logic [CNT_W-1:0] cyc_left;
    own_state_t       state;

    assign need_bus = core_ext_req && kind_is_external(bus_kind);

    bha_cycle_timer #(
        .WS_W  (WS_W),
        .CNT_W (CNT_W)
    ) u_timer (
        .clk         (clk),
        .rst         (rst),
        .tick        (state_tick),
        .start       (start_cycle),
        .kind        (bus_kind),
        .waits       (wait_states),
        .cyc_left    (cyc_left),
        .at_boundary (at_boundary),
        .cyc_idle    (cyc_idle)
    );

    bha_own_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .tick        (state_tick),
        .hold_n      (hold_n),
        .need_bus    (need_bus),
        .at_boundary (at_boundary),
        .cyc_idle    (cyc_idle),
        .state       (state),
        .start_cycle (start_cycle),
        .hlda_n      (hlda_n),
        .breq_n      (breq_n),
        .drive_en    (bus_drive_en),
        .stall       (core_stall),
        .irq_block   (irq_block)
    );

    bha_irq_gate u_gate (
        .block      (irq_block),
        .irq_pend   (irq_pend),
        .nmi_pend   (nmi_pend),
        .irq_accept (irq_accept),
        .nmi_accept (nmi_accept)
    );

endmodule

// File: rtl/bha_checker.sv
module bha_checker #(
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             state_tick,
    input logic             hold_n,
    input logic             hlda_n,
    input logic             breq_n,
    input logic             bus_drive_en,
    input logic             irq_accept,
    input logic             nmi_accept,
    input logic [CNT_W-1:0] cyc_left
);

    // R1
    reset_owns_bus_chk: assert property (@(posedge clk)
        rst |=> (hlda_n && breq_n && bus_drive_en));

    // R2
    no_drive_in_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !hlda_n |-> !bus_drive_en);

    // R2
    grant_at_boundary_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(hlda_n) |-> (cyc_left == '0));

    // R10
    held_no_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        !hlda_n |-> (cyc_left == '0));

    // R7
    breq_inside_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !breq_n |-> !hlda_n);

    // R8
    irq_masked_chk: assert property (@(posedge clk) disable iff (rst)
        !breq_n |-> (!irq_accept && !nmi_accept));

    // R9
    release_one_tick_chk: assert property (@(posedge clk) disable iff (rst)
        (state_tick && hold_n && !hlda_n) |=> (hlda_n && breq_n && bus_drive_en));

    // R11
    tick_gated_chk: assert property (@(posedge clk) disable iff (rst)
        (!state_tick && !rst) |=> ($stable(hlda_n) && $stable(breq_n)));

endmodule

bind bus_hold_arbiter bha_checker #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .state_tick   (state_tick),
    .hold_n       (hold_n),
    .hlda_n       (hlda_n),
    .breq_n       (breq_n),
    .bus_drive_en (bus_drive_en),
    .irq_accept   (irq_accept),
    .nmi_accept   (nmi_accept),
    .cyc_left     (cyc_left)
);

// File: tb/bus_hold_arbiter_test.sv
module bus_hold_arbiter_test;

    localparam int CLK_PERIOD = 10;
    localparam int WS_W       = 3;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            state_tick;
    logic            hold_n = 1'b1;
    logic            core_ext_req = 1'b0;
    logic [1:0]      bus_kind = 2'b00;
    logic [WS_W-1:0] wait_states = '0;
    logic            irq_pend = 1'b0;
    logic            nmi_pend = 1'b0;
    logic            hlda_n, breq_n, bus_drive_en, core_stall, irq_accept, nmi_accept;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always_ff @(posedge clk) begin
        if (rst) state_tick <= 1'b0;
        else     state_tick <= ~state_tick;
    end

    bus_hold_arbiter #(.WS_W(WS_W)) uut (
        .clk          (clk),
        .rst          (rst),
        .state_tick   (state_tick),
        .hold_n       (hold_n),
        .core_ext_req (core_ext_req),
        .bus_kind     (bus_kind),
        .wait_states  (wait_states),
        .irq_pend     (irq_pend),
        .nmi_pend     (nmi_pend),
        .hlda_n       (hlda_n),
        .breq_n       (breq_n),
        .bus_drive_en (bus_drive_en),
        .core_stall   (core_stall),
        .irq_accept   (irq_accept),
        .nmi_accept   (nmi_accept)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // advance to just after the next clock edge that carried a tick
    task automatic next_tick();
        bit was;
        do begin
            was = state_tick;
            @(posedge clk);
            #1;
        end while (!was);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        check(hlda_n == 1'b1, "R1 hlda_n", hlda_n, 1);
        check(breq_n == 1'b1, "R1 breq_n", breq_n, 1);
        check(bus_drive_en == 1'b1, "R1 bus_drive_en", bus_drive_en, 1);
    endtask

    task automatic release_hold();
        hold_n = 1'b1;
        next_tick();
        check(hlda_n == 1'b1, "R9 hlda_n after release", hlda_n, 1);
        check(bus_drive_en == 1'b1, "R9 drive after release", bus_drive_en, 1);
    endtask

    // worst case: hold arrives right after an external cycle started
    task automatic t_latency(input logic [1:0] kind, input int ws, input string req);
        int n;
        int exp;
        int bound2;
        exp    = (kind == 2'b01) ? 2 + ws : (kind == 2'b10) ? 2 + 2 * ws : 1;
        bound2 = (kind == 2'b01) ? 5 + 2 * ws : (kind == 2'b10) ? 5 + 4 * ws : 3;
        next_tick();
        core_ext_req = 1'b1;
        bus_kind     = kind;
        wait_states  = WS_W'(ws);
        next_tick();
        hold_n       = 1'b0;
        core_ext_req = 1'b0;
        n = 0;
        do begin
            next_tick();
            n++;
        end while (hlda_n && n < 60);
        check(n == exp, {req, " grant latency"}, n, exp);
        check(2 * n <= bound2, {req, " latency within bound x2"}, 2 * n, bound2);
        check(bus_drive_en == 1'b0, "R2 drive off with hlda", bus_drive_en, 0);
        release_hold();
    endtask

    task automatic t_tick_gating();
        next_tick();
        if (!state_tick) begin
            @(posedge clk);
            #1;
        end
        // next edge carries a tick; move past it so the following edge does not
        @(posedge clk);
        #1;
        hold_n = 1'b0;
        @(posedge clk);
        #1;
        check(hlda_n == 1'b1, "R11 no change between ticks", hlda_n, 1);
        next_tick();
        check(hlda_n == 1'b0, "R11 grant on tick", hlda_n, 0);
        release_hold();
    endtask

    task automatic t_run_in_hold();
        hold_n = 1'b0;
        next_tick();
        check(hlda_n == 1'b0, "R3 held", hlda_n, 0);
        core_ext_req = 1'b1;
        bus_kind     = 2'b00;
        #1;
        check(core_stall == 1'b0, "R6 no stall internal", core_stall, 0);
        next_tick();
        check(breq_n == 1'b1, "R6 no breq internal", breq_n, 1);
        nmi_pend = 1'b1;
        irq_pend = 1'b1;
        #1;
        check(nmi_accept == 1'b1, "R8 nmi taken in plain hold", nmi_accept, 1);
        nmi_pend = 1'b0;
        irq_pend = 1'b0;
        core_ext_req = 1'b0;
        release_hold();
    endtask

    task automatic t_reclaim();
        hold_n = 1'b0;
        next_tick();
        core_ext_req = 1'b1;
        bus_kind     = 2'b01;
        wait_states  = WS_W'(1);
        irq_pend     = 1'b1;
        nmi_pend     = 1'b1;
        #1;
        check(core_stall == 1'b1, "R7 stall at once", core_stall, 1);
        next_tick();
        check(breq_n == 1'b0, "R7 breq low", breq_n, 0);
        check(nmi_accept == 1'b0, "R8 nmi blocked", nmi_accept, 0);
        check(irq_accept == 1'b0, "R8 irq blocked", irq_accept, 0);
        next_tick();
        next_tick();
        check(breq_n == 1'b0, "R7 breq held", breq_n, 0);
        check(hlda_n == 1'b0, "R7 still in hold", hlda_n, 0);
        hold_n = 1'b1;
        next_tick();
        check(hlda_n == 1'b1, "R9 hlda up after one state", hlda_n, 1);
        check(breq_n == 1'b1, "R9 breq up", breq_n, 1);
        check(bus_drive_en == 1'b1, "R9 drive back", bus_drive_en, 1);
        check(nmi_accept == 1'b1, "R8 nmi after release", nmi_accept, 1);
        irq_pend = 1'b0;
        nmi_pend = 1'b0;
        hold_n   = 1'b0;
        next_tick();
        check(hlda_n == 1'b1, "R10 no grant at access start", hlda_n, 1);
        core_ext_req = 1'b0;
        next_tick();
        next_tick();
        check(hlda_n == 1'b1, "R10 no grant mid access", hlda_n, 1);
        next_tick();
        check(hlda_n == 1'b0, "R10 grant after access", hlda_n, 0);
        release_hold();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_latency(2'b00, 0, "R3");
        t_latency(2'b11, 2, "R3");
        t_latency(2'b01, 0, "R4");
        t_latency(2'b01, 3, "R4");
        t_latency(2'b10, 0, "R5");
        t_latency(2'b10, 2, "R5");
        t_latency(2'b10, 7, "R5");
        t_tick_gating();
        t_run_in_hold();
        t_reclaim();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule